// File: doc/BRIEF.md
# Thermocouple Converter Serial Poller

This block reads a thermocouple-to-digital converter over a receive-only SPI link, over and over. The converter starts a conversion when its chip select is released and abandons that conversion if chip select is pulled low before it finishes. The poller therefore keeps chip select high for a programmable number of system clocks after every read, and only then takes it low again. The interval must cover the converter's worst-case conversion time of 0.22 s, and the default is 250 ms.

A read is one 16-bit frame, shifted in most significant bit first. The serial clock comes from a divider on the system clock, idles low, and has no lower frequency limit. Once the frame is complete, the poller releases chip select and, in that same cycle, gives a one-cycle valid pulse. With the pulse it presents the raw frame, the 12-bit temperature count (quarter-degree steps), the three low status bits and the temperature truncated to whole degrees Celsius. An enable input gates the start of new reads. A read that has already begun always runs to its end.

Top module: `thermo_spi_poller`

## Requirements
- R1: While reset is high and in the first cycle after it, cs_n is 1, sck is 0, sample_valid is 0, and frame_raw, temp_count, status and temp_c are all zero.
- R2: sck is 0 in every cycle in which cs_n is 1. When cs_n falls, sck stays 0 for exactly SCK_HALF system cycles before its first rise.
- R3: With enable held at 1, cs_n stays high for exactly WAIT_CYCLES system cycles, both after reset is released and after each frame ends, before it goes low again.
- R4: A frame holds cs_n low for exactly 2*FRAME_W*SCK_HALF cycles. It contains FRAME_W sck pulses, each high for SCK_HALF cycles and low for SCK_HALF cycles.
- R5: miso is sampled on the system clock edge that raises sck. The first bit sampled ends up in frame_raw[15] and the last one in frame_raw[0].
- R6: sample_valid is a single-cycle pulse. It occurs in the cycle in which cs_n returns to 1 at the end of a frame, and never at any other time.
- R7: temp_count equals frame_raw[14:3] and status equals frame_raw[2:0]. Bit 15 is a dummy bit and is not decoded.
- R8: temp_c equals temp_count divided by 4, with the fraction dropped (one count is 0.25 °C).
- R9: While enable is 0, no new frame starts. If enable rises after the wait has already run out, cs_n falls on the next clock edge. Dropping enable during a frame does not cut the frame short.
- R10: frame_raw, temp_count, status and temp_c change only in a cycle in which sample_valid is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows new frames to start |
| sck | output | 1 | Serial clock to the converter, idles low |
| cs_n | output | 1 | Chip select, active low; its rising edge starts a conversion |
| miso | input | 1 | Serial data from the converter |
| sample_valid | output | 1 | One-cycle pulse when a new frame is presented |
| frame_raw | output | FRAME_W | Last complete frame, MSB first |
| temp_count | output | DATA_W | Temperature count in quarter degrees |
| status | output | STAT_W | Low status bits of the frame |
| temp_c | output | DATA_W-FRAC_BITS | Temperature in whole degrees Celsius |

## Verification
The bench drives a converter model that changes miso on falling sck edges. It goes after the boundary cycles of each phase. The length of the chip-select gap is measured exactly, so a wait counter that is off by one, or one that starts at the wrong point, gives the wrong count. The low lead-in before the first sck rise is measured too, because a design that samples on the wrong edge or raises sck at once would shift every bit by one place. The frame patterns include a set dummy bit, an all-ones count and an odd count: these expose a field extracted off by one bit, a rounded division, or a dummy bit that leaks into the count. The enable tests drop enable both during the wait and in the middle of a frame. A design that aborts the frame would deliver fewer than sixteen pulses, and one that ignores enable would start a read while it should hold.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

   typedef enum logic {
      ST_WAIT  = 1'b0,
      ST_SHIFT = 1'b1
   } tcp_state_e;

   // Counter width able to hold values 0..n-1, never below one bit.
   function automatic int unsigned tcp_cw(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/tcp_wait_timer.sv
module tcp_wait_timer #(
   parameter int unsigned WAIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   output logic done
);
   localparam int unsigned CW = tcp_pkg::tcp_cw(WAIT_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign done = (cnt_q == LAST);

   // Counts up from the cycle chip select rises and parks on the last value.
   always_ff @(posedge clk) begin
      if (rst || clr)
         cnt_q <= '0;
      else if (!done)
         cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/tcp_sck_gen.sv
module tcp_sck_gen #(
   parameter int unsigned SCK_HALF = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   localparam int unsigned PW = tcp_pkg::tcp_cw(SCK_HALF);
   localparam logic [PW-1:0] PH_LAST = PW'(SCK_HALF - 1);

   logic [PW-1:0] ph_q;

   assign tick = run && (ph_q == PH_LAST);

   always_ff @(posedge clk) begin
      if (rst || !run)
         ph_q <= '0;
      else if (tick)
         ph_q <= '0;
      else
         ph_q <= ph_q + PW'(1);
   end
endmodule

// File: rtl/tcp_shifter.sv
module tcp_shifter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] word
);
   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)
               word <= '0;
            else if (shift_en)
               word <= din;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)
               word <= '0;
            else if (shift_en)
               word <= {word[W-2:0], din};
         end
      end
   endgenerate
endmodule

// File: rtl/tcp_decode.sv
module tcp_decode #(
   parameter int unsigned DATA_W    = 12,
   parameter int unsigned FRAC_BITS = 2
) (
   input  logic [DATA_W-1:0]           count,
   output logic [DATA_W-FRAC_BITS-1:0] whole
);
   localparam int unsigned WW = DATA_W - FRAC_BITS;

   generate
      if (FRAC_BITS == 0) begin : g_int
         assign whole = count;
      end else begin : g_frac
         // Truncating divide by 2**FRAC_BITS.
         assign whole = WW'(count >> FRAC_BITS);
      end
   endgenerate
endmodule

// File: rtl/thermo_spi_poller.sv
module thermo_spi_poller #(
   parameter int unsigned CLK_HZ           = 125_000_000,
   parameter int unsigned SCK_HALF         = 16,
   parameter int unsigned MAX_SCK_HZ       = 4_300_000,
   parameter int unsigned WAIT_CYCLES      = 31_250_000,
   parameter bit          ENFORCE_MIN_WAIT = 1'b1,
   parameter int unsigned FRAME_W          = 16,
   parameter int unsigned DATA_W           = 12,
   parameter int unsigned STAT_W           = 3,
   parameter int unsigned FRAC_BITS        = 2
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          enable,
   output logic                          sck,
   output logic                          cs_n,
   input  logic                          miso,
   output logic                          sample_valid,
   output logic [FRAME_W-1:0]            frame_raw,
   output logic [DATA_W-1:0]             temp_count,
   output logic [STAT_W-1:0]             status,
   output logic [DATA_W-FRAC_BITS-1:0]   temp_c
);
   import tcp_pkg::*;

   localparam int unsigned BW       = tcp_cw(FRAME_W);
   localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_W - 1);
   localparam int unsigned DATA_LSB = STAT_W;
   localparam int unsigned SCK_HZ   = CLK_HZ / (2 * SCK_HALF);
   localparam int unsigned MIN_WAIT = CLK_HZ / 4;

   // Elaboration-time parameter checks.
   generate
      if (SCK_HALF < 1) begin : g_bad_half
         $error("SCK_HALF must be at least 1");
      end
      if (SCK_HZ > MAX_SCK_HZ) begin : g_bad_rate
         $error("serial clock rate exceeds MAX_SCK_HZ");
      end
      if (WAIT_CYCLES < 1) begin : g_bad_wait
         $error("WAIT_CYCLES must be at least 1");
      end
      if (ENFORCE_MIN_WAIT && (WAIT_CYCLES < MIN_WAIT)) begin : g_short_wait
         $error("WAIT_CYCLES is below 250 ms at CLK_HZ");
      end
      if (FRAME_W < DATA_W + STAT_W) begin : g_bad_frame
         $error("FRAME_W cannot hold the data and status fields");
      end
      if (FRAC_BITS >= DATA_W) begin : g_bad_frac
         $error("FRAC_BITS must be below DATA_W");
      end
   endgenerate

   tcp_state_e       state_q;
   logic [BW-1:0]    bit_q;
   logic             tick;
   logic             wait_done;
   logic             sample_en;
   logic             frame_end;
   logic [FRAME_W-1:0] shift_word;
   logic [FRAME_W-1:0] frame_q;

   assign sample_en = (state_q == ST_SHIFT) && tick && !sck;
   assign frame_end = (state_q == ST_SHIFT) && tick && sck && (bit_q == BIT_LAST);

   tcp_wait_timer #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_wait (
      .clk  (clk),
      .rst  (rst),
      .clr  (frame_end),
      .done (wait_done)
   );

   tcp_sck_gen #(
      .SCK_HALF (SCK_HALF)
   ) u_sck (
      .clk  (clk),
      .rst  (rst),
      .run  (state_q == ST_SHIFT),
      .tick (tick)
   );

   tcp_shifter #(
      .W (FRAME_W)
   ) u_shift (
      .clk      (clk),
      .rst      (rst),
      .shift_en (sample_en),
      .din      (miso),
      .word     (shift_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_WAIT;
         cs_n         <= 1'b1;
         sck          <= 1'b0;
         bit_q        <= '0;
         sample_valid <= 1'b0;
         frame_q      <= '0;
      end else begin
         sample_valid <= 1'b0;
         unique case (state_q)
            ST_WAIT: begin
               if (wait_done && enable) begin
                  state_q <= ST_SHIFT;
                  cs_n    <= 1'b0;
                  sck     <= 1'b0;
                  bit_q   <= '0;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!sck) begin
                     sck <= 1'b1;
                  end else begin
                     sck <= 1'b0;
                     if (bit_q == BIT_LAST) begin
                        cs_n         <= 1'b1;
                        state_q      <= ST_WAIT;
                        sample_valid <= 1'b1;
                        frame_q      <= shift_word;
                     end else begin
                        bit_q <= bit_q + BW'(1);
                     end
                  end
               end
            end
            default: state_q <= ST_WAIT;
         endcase
      end
   end

   assign frame_raw  = frame_q;
   assign temp_count = frame_q[DATA_LSB +: DATA_W];
   assign status     = frame_q[STAT_W-1:0];

   tcp_decode #(
      .DATA_W    (DATA_W),
      .FRAC_BITS (FRAC_BITS)
   ) u_decode (
      .count (temp_count),
      .whole (temp_c)
   );
endmodule

// File: rtl/thermo_spi_poller_chk.sv
module thermo_spi_poller_chk #(
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned WAIT_CYCLES = 16
) (
   input logic               clk,
   input logic               rst,
   input logic               sck,
   input logic               cs_n,
   input logic               sample_valid,
   input logic [FRAME_W-1:0] frame_raw
);
   localparam int unsigned GW = tcp_pkg::tcp_cw(WAIT_CYCLES + 2);
   localparam int unsigned RW = tcp_pkg::tcp_cw(FRAME_W + 2);

   logic [GW-1:0] gap_q;
   logic [RW-1:0] rise_q;
   logic          sck_prev_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q      <= '0;
         rise_q     <= '0;
         sck_prev_q <= 1'b0;
      end else begin
         sck_prev_q <= sck;
         if (!cs_n)
            gap_q <= '0;
         else if (gap_q != GW'(WAIT_CYCLES))
            gap_q <= gap_q + GW'(1);
         if (cs_n)
            rise_q <= '0;
         else if (sck && !sck_prev_q && (rise_q != RW'(FRAME_W + 1)))
            rise_q <= rise_q + RW'(1);
      end
   end

   AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
      cs_n |-> !sck);                                              // R2
   AST_START_SCK_LOW: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> !sck);                                       // R2
   AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
      $fell(cs_n) |-> (gap_q >= GW'(WAIT_CYCLES)));                // R3
   AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (rst)
      $rose(cs_n) |-> (rise_q == RW'(FRAME_W)));                   // R4
   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
      sample_valid |=> !sample_valid);                             // R6
   AST_VALID_AT_END: assert property (@(posedge clk) disable iff (rst)
      sample_valid |-> $rose(cs_n));                               // R6
   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (rst)
      !sample_valid |-> $stable(frame_raw));                       // R10
endmodule

bind thermo_spi_poller thermo_spi_poller_chk #(
   .FRAME_W     (FRAME_W),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .sck          (sck),
   .cs_n         (cs_n),
   .sample_valid (sample_valid),
   .frame_raw    (frame_raw)
);

// File: tb/thermo_spi_poller_test.sv
module thermo_spi_poller_test;
   localparam int HALF  = 2;
   localparam int WAITC = 40;
   localparam int FW    = 16;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic enable = 1'b0;
   logic miso;
   logic sck, cs_n, sample_valid;
   logic [15:0] frame_raw;
   logic [11:0] temp_count;
   logic [2:0]  status;
   logic [9:0]  temp_c;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   thermo_spi_poller #(
      .CLK_HZ(16_000_000), .SCK_HALF(HALF), .WAIT_CYCLES(WAITC),
      .ENFORCE_MIN_WAIT(1'b0)
   ) uut (
      .clk(clk), .rst(rst), .enable(enable), .sck(sck), .cs_n(cs_n),
      .miso(miso), .sample_valid(sample_valid), .frame_raw(frame_raw),
      .temp_count(temp_count), .status(status), .temp_c(temp_c)
   );

   // Converter model: loads a frame when selected, advances on falling sck.
   logic [15:0] dev_frame = 16'h0000;
   logic [15:0] dev_sh = 16'h0000;
   always @(negedge cs_n) dev_sh = dev_frame;
   always @(negedge sck) if (!cs_n) dev_sh = {dev_sh[14:0], 1'b0};
   assign miso = cs_n ? 1'b0 : dev_sh[15];

   // Pin monitor, sampled at falling clk edges.
   int hi_run, lo_run, rises, hw_run, hw_min, hw_max, lead;
   int last_gap, last_lo, last_rises, last_hwmin, last_hwmax;
   int frames, valid_cnt;
   bit cs_prev, sck_prev, idle_bad, sck_at_fall, v_at_rise;
   logic [15:0] raw_at_rise;
   logic [11:0] cnt_at_rise;
   logic [2:0]  st_at_rise;
   logic [9:0]  c_at_rise;

   always @(negedge clk) begin
      if (rst) begin
         hi_run = 0; lo_run = 0; rises = 0; hw_run = 0; lead = 0;
         hw_min = 1000000; hw_max = 0; frames = 0; valid_cnt = 0;
         cs_prev = 1; sck_prev = 0; idle_bad = 0;
      end else begin
         if (sck) hw_run++;
         else if (sck_prev) begin
            if (hw_run < hw_min) hw_min = hw_run;
            if (hw_run > hw_max) hw_max = hw_run;
            hw_run = 0;
         end
         if (!cs_n) begin
            if (cs_prev) begin
               last_gap = hi_run; hi_run = 0; lo_run = 0; rises = 0;
               hw_min = 1000000; hw_max = 0; sck_at_fall = sck;
            end
            lo_run++;
            if (sck && !sck_prev) begin
               if (rises == 0) lead = lo_run - 1;
               rises++;
            end
         end else begin
            if (!cs_prev) begin
               last_lo = lo_run; last_rises = rises;
               last_hwmin = hw_min; last_hwmax = hw_max;
               v_at_rise = sample_valid; raw_at_rise = frame_raw;
               cnt_at_rise = temp_count; st_at_rise = status; c_at_rise = temp_c;
               frames++;
            end
            hi_run++;
            if (sck) idle_bad = 1;
         end
         if (sample_valid) valid_cnt++;
         cs_prev = cs_n;
         sck_prev = sck;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wait_frame();
      int f0 = frames;
      while (frames == f0) @(posedge clk);
   endtask

   task automatic check_frame(input logic [15:0] pat, input bit chk_gap);
      int ec = (pat >> 3) & 12'hFFF;
      wait_frame();
      if (chk_gap) chk("R3", "chip select gap", last_gap, WAITC);
      chk("R2", "sck when cs falls", sck_at_fall, 0);
      chk("R2", "lead-in low cycles", lead, HALF);
      chk("R2", "sck high while idle", idle_bad, 0);
      chk("R4", "cs low length", last_lo, 2 * FW * HALF);
      chk("R4", "sck pulses", last_rises, FW);
      chk("R4", "min high width", last_hwmin, HALF);
      chk("R4", "max high width", last_hwmax, HALF);
      chk("R6", "valid at cs rise", v_at_rise, 1);
      chk("R5", "raw frame", raw_at_rise, pat);
      chk("R7", "temp count", cnt_at_rise, ec);
      chk("R7", "status", st_at_rise, pat & 16'h7);
      chk("R8", "whole degrees", c_at_rise, ec / 4);
      @(posedge clk); @(posedge clk);
      chk("R6", "valid cycles per frame", valid_cnt, frames);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R1", "cs_n in reset", cs_n, 1);
      chk("R1", "sck in reset", sck, 0);
      chk("R1", "valid in reset", sample_valid, 0);
      chk("R1", "frame in reset", frame_raw, 0);
      chk("R1", "temp_c in reset", temp_c, 0);
      dev_frame = 16'h7FF8;
      enable = 1'b1;
      @(posedge clk); #2 rst = 1'b0;
      @(negedge clk);
      chk("R1", "cs_n after reset", cs_n, 1);
      chk("R1", "count after reset", temp_count, 0);
   endtask

   task automatic t_patterns();
      check_frame(16'h7FF8, 1);
      dev_frame = 16'h8005; check_frame(16'h8005, 1);
      dev_frame = 16'h1234; check_frame(16'h1234, 1);
      dev_frame = 16'h0338; check_frame(16'h0338, 1);
      dev_frame = 16'h0320; check_frame(16'h0320, 1);
   endtask

   task automatic t_enable_idle();
      int f0;
      @(posedge clk); #2 enable = 1'b0;
      f0 = frames;
      repeat (3 * WAITC) @(posedge clk);
      #2;
      chk("R9", "frames while disabled", frames, f0);
      chk("R9", "cs_n while disabled", cs_n, 1);
      chk("R10", "frame held", frame_raw, 16'h0320);
      chk("R10", "valid cycles held", valid_cnt, f0);
      dev_frame = 16'h4A5B;
      @(posedge clk); #2 enable = 1'b1;
      @(negedge clk);
      chk("R9", "cs_n before enable edge", cs_n, 1);
      @(negedge clk);
      chk("R9", "cs_n after enable edge", cs_n, 0);
      check_frame(16'h4A5B, 0);
   endtask

   task automatic t_enable_midframe();
      int f0;
      dev_frame = 16'h2C4F;
      while (cs_n) @(negedge clk);
      @(posedge clk); #2 enable = 1'b0;
      f0 = frames;
      wait_frame();
      chk("R9", "pulses after mid-frame disable", last_rises, FW);
      chk("R9", "frame after mid-frame disable", raw_at_rise, 16'h2C4F);
      repeat (2 * WAITC) @(posedge clk);
      chk("R9", "no frame after disable", frames, f0 + 1);
      @(posedge clk); #2 enable = 1'b1;
   endtask

   initial begin
      t_reset();
      t_patterns();
      t_enable_idle();
      t_enable_midframe();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=expired expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule